// File: doc/BRIEF.md
# Fractional-N Divider Sequencer

This block sequences the main loop divider of a fractional-N synthesizer. It runs on the VCO-rate clock. It emits a one-clock output pulse at the end of every divider cycle. Each cycle lasts either N or N+1 clocks. A small fractional accumulator picks the longer ratio whenever it overflows, so the average ratio is N plus the numerator divided by the selected modulus. The modulus is either 5 or 8.

Alongside the divider, the block issues a spur-compensation request at the start of every cycle. The request is a pulse of fixed width, and while it is high it carries an amplitude code equal to the accumulator value times an 8-bit DAC code. An analog stage outside this block turns that code into a current.

The ratio, numerator, modulus select and DAC code arrive as plain register-bank levels. The block reads them only at cycle boundaries. When the loop is switched off, the block clears itself. When the loop is switched back on, it waits for a synchronizing strobe from the reference divider before it starts counting.

Top module: `fracn_div_seq`

## Requirements
- R1: While the accumulator does not overflow, `div_pulse` is high for exactly one clock every `ratio_n` clocks, and never for two clocks in a row.
- R2: At each boundary the accumulator adds the numerator and wraps at the modulus. `mod_sel` = 0 selects modulo 8 and `mod_sel` = 1 selects modulo 5. A boundary that wraps makes the following cycle `ratio_n`+1 clocks long.
- R3: A numerator greater than or equal to the modulus is reduced by the modulus before it is added (for example, 7 at modulo 5 behaves as 2).
- R4: `ratio_n`, `frac_num`, `mod_sel` and `dac_code` are sampled only at the clock edge that ends a cycle. Changing them mid-cycle and restoring them before that edge has no effect on any output.
- R5: When the sampled `mod_sel` differs from the one in use, the accumulator restarts from 0 before the numerator is added.
- R6: `comp_active` rises in the clock right after each `div_pulse` and stays high for exactly 128 clocks.
- R7: While `comp_active` is high, `comp_code` equals the new accumulator value times the `dac_code` sampled at that boundary, and it holds steady for the whole pulse. While `comp_active` is low, `comp_code` is 0.
- R8: While `enable` is low, the counter and accumulator are cleared. From the next clock on, `div_pulse` and `comp_active` stay low.
- R9: After `enable` returns high, nothing happens until `ref_sync` is high. That clock edge starts a first cycle of `ratio_n` clocks, with the accumulator at 0 and a compensation code of 0.
- R10: Ratios across 512 to 65535 are honored, including 65535 with an overflow, which gives a 65536-clock cycle.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Loop powered up when high |
| ref_sync | input | 1 | Start strobe from the reference divider |
| ratio_n | input | 16 | Integer ratio N |
| frac_num | input | 3 | Fractional numerator |
| mod_sel | input | 1 | 0 selects modulo 8, 1 selects modulo 5 |
| dac_code | input | 8 | Compensation DAC code |
| div_pulse | output | 1 | One-clock end-of-cycle pulse |
| comp_active | output | 1 | Compensation pulse window |
| comp_code | output | 11 | Compensation amplitude code |

## Verification
The assertions watch properties that hold on every clock:
- a single-clock divider pulse;
- a compensation window that opens right after each pulse and closes after exactly 128 clocks;
- a code that stays steady inside the window;
- silence on the clock after power-down.

Only the bench scenarios can show the arithmetic itself. These cover cycle lengths, when N+1 appears, numerator reduction, the accumulator restarting on a modulus change, the products carried in each code, and the fact that mid-cycle register changes and a missing sync strobe leave the outputs untouched.

// File: rtl/fracn_pkg.sv
// Shared types for the fractional-N divider sequencer.
// Assumes a 3-bit accumulator, so both moduli fit in 4 bits.
package fracn_pkg;
    typedef enum logic {
        MOD_EIGHT = 1'b0,
        MOD_FIVE  = 1'b1
    } fmod_e;

    // Maps the modulus select onto its wrap value.
    function automatic logic [3:0] mod_value(input fmod_e m);
        return (m == MOD_FIVE) ? 4'd5 : 4'd8;
    endfunction
endpackage

// File: rtl/fracn_accum.sv
// Fractional accumulator.
// It advances by the reduced numerator on each cycle boundary and reports
// the wrap as a carry. The carry is valid in the clock where step is high.
// Assumes FW = 3, which matches the 4-bit modulus values in fracn_pkg.
module fracn_accum #(
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          launch,
    input  logic          step,
    input  logic [FW-1:0] num,
    input  logic          mod_sel,
    output logic [FW-1:0] acc,
    output logic          carry
);
    import fracn_pkg::*;
    localparam int SW = FW + 1;

    fmod_e         mod_in, mod_act;
    logic [SW-1:0] mval, num_red, base, sum;

    // Next-state arithmetic: reduce, add, wrap.
    always_comb begin
        mod_in  = fmod_e'(mod_sel);
        mval    = mod_value(mod_in);
        num_red = ({1'b0, num} >= mval) ? ({1'b0, num} - mval) : {1'b0, num};
        base    = (mod_in != mod_act) ? '0 : {1'b0, acc};
        sum     = base + num_red;
        carry   = (sum >= mval);
    end

    // Accumulator and modulus-in-use registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc     <= '0;
            mod_act <= MOD_EIGHT;
        end else if (launch) begin
            acc     <= '0;
            mod_act <= mod_in;
        end else if (step) begin
            acc     <= carry ? FW'(sum - mval) : FW'(sum);
            mod_act <= mod_in;
        end
    end
endmodule

// File: rtl/fracn_cycle_cnt.sv
// Divider cycle counter.
// It counts down N-1 or N (with carry) to zero. It starts only on a
// sync strobe while idle, and it is cleared whenever enable is low.
module fracn_cycle_cnt #(
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          ref_sync,
    input  logic [NW-1:0] n_in,
    input  logic          carry,
    output logic          launch,
    output logic          wrap
);
    logic          running;
    logic [NW-1:0] cnt;

    // Start and end-of-cycle events.
    always_comb begin
        launch = enable && !running && ref_sync;
        wrap   = running && (cnt == '0);
    end

    // Down-counter with a reload on each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (launch) begin
            running <= 1'b1;
            cnt     <= n_in - NW'(1);
        end else if (wrap) begin
            cnt     <= n_in - NW'(1) + NW'(carry);
        end else if (running) begin
            cnt     <= cnt - NW'(1);
        end
    end
endmodule

// File: rtl/fracn_comp_pulse.sv
// Compensation pulse generator.
// Each tick opens a window PW clocks wide and latches the DAC code. The
// output code is the accumulator value times the latched code, and it is
// forced to zero outside the window.
module fracn_comp_pulse #(
    parameter int PW = 128,
    parameter int FW = 3,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic [DW-1:0]    dac_in,
    input  logic [FW-1:0]    acc,
    output logic             comp_active,
    output logic [FW+DW-1:0] comp_code
);
    localparam int CW = $clog2(PW + 1);
    localparam int OW = FW + DW;

    logic [CW-1:0] left;
    logic [DW-1:0] dac_q;

    // Window countdown and DAC code capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            left  <= '0;
            dac_q <= '0;
        end else if (tick) begin
            left  <= CW'(PW);
            dac_q <= dac_in;
        end else if (left != '0) begin
            left  <= left - CW'(1);
        end
    end

    // Amplitude code gated by the window.
    always_comb begin
        comp_active = (left != '0);
        comp_code   = comp_active ? (OW'(acc) * OW'(dac_q)) : '0;
    end
endmodule

// File: rtl/fracn_div_seq.sv
// Top of the fractional-N divider sequencer.
// It wires the cycle counter, the fractional accumulator and the
// compensation pulse generator together. Assumes ratio_n >= 512, which is
// well above the PULSE_W window.
module fracn_div_seq #(
    parameter int NW      = 16,
    parameter int FW      = 3,
    parameter int DW      = 8,
    parameter int PULSE_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ref_sync,
    input  logic [NW-1:0]    ratio_n,
    input  logic [FW-1:0]    frac_num,
    input  logic             mod_sel,
    input  logic [DW-1:0]    dac_code,
    output logic             div_pulse,
    output logic             comp_active,
    output logic [FW+DW-1:0] comp_code
);
    logic          launch, wrap, carry, tick;
    logic [FW-1:0] acc;

    // A cycle begins on a launch or on a wrap.
    assign tick      = launch || wrap;
    assign div_pulse = wrap;

    fracn_cycle_cnt #(.NW(NW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ref_sync(ref_sync),
        .n_in(ratio_n), .carry(carry), .launch(launch), .wrap(wrap)
    );

    fracn_accum #(.FW(FW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(!enable), .launch(launch),
        .step(wrap), .num(frac_num), .mod_sel(mod_sel),
        .acc(acc), .carry(carry)
    );

    fracn_comp_pulse #(.PW(PULSE_W), .FW(FW), .DW(DW)) u_comp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .dac_in(dac_code), .acc(acc),
        .comp_active(comp_active), .comp_code(comp_code)
    );
endmodule

// File: rtl/fracn_div_seq_chk.sv
// Protocol checker for fracn_div_seq, attached through bind.
// It measures each compensation window with a local counter.
module fracn_div_seq_chk #(
    parameter int PW     = 128,
    parameter int CODE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              div_pulse,
    input logic              comp_active,
    input logic [CODE_W-1:0] comp_code
);
    localparam int CW = $clog2(PW + 2);
    logic [CW-1:0] run_len;

    // Counts consecutive clocks with the window open.
    always_ff @(posedge clk) begin
        if (!rst_n || !comp_active) run_len <= '0;
        else                        run_len <= run_len + CW'(1);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);                                        // R1
    AST_COMP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && enable) |=> comp_active);                           // R6
    AST_COMP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(comp_active) && $past(enable)) |-> (run_len == CW'(PW)));  // R6
    AST_COMP_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        comp_active |-> (run_len < CW'(PW)));                             // R6
    AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        comp_active |=> (!comp_active || $stable(comp_code)));            // R7
    AST_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!div_pulse && !comp_active));                        // R8
endmodule

bind fracn_div_seq fracn_div_seq_chk #(.PW(PULSE_W), .CODE_W(FW + DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_pulse(div_pulse),
    .comp_active(comp_active), .comp_code(comp_code)
);

// File: tb/sim_fracn_div_seq.sv
// Scoreboard bench for fracn_div_seq.
// The driver pushes the expected cycle records; the monitor measures them.
module sim_fracn_div_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        ref_sync = 1'b0;
    logic [15:0] ratio_n = 16'd520;
    logic [2:0]  frac_num = 3'd0;
    logic        mod_sel = 1'b0;
    logic [7:0]  dac_code = 8'd0;
    logic        div_pulse, comp_active;
    logic [10:0] comp_code;

    typedef struct { int len; int code; } item_t;
    item_t q[$];

    int    tests = 0, fails = 0;
    int    m_acc = 0, m_mod = 8;
    string phase = "R11 reset";
    bit    done = 0;

    always #4 clk = ~clk;

    fracn_div_seq u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ref_sync(ref_sync),
        .ratio_n(ratio_n), .frac_num(frac_num), .mod_sel(mod_sel),
        .dac_code(dac_code), .div_pulse(div_pulse),
        .comp_active(comp_active), .comp_code(comp_code)
    );

    // Records one check; prints a failure line when it does not hold.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s [%s]: actual %0d expected %0d", req, phase, act, exp);
        end
    endtask

    // Reference model: expected record for the cycle after a boundary.
    task automatic push_next();
        int mv, nr, base, s, c;
        mv   = mod_sel ? 5 : 8;
        nr   = (int'(frac_num) >= mv) ? int'(frac_num) - mv : int'(frac_num);
        base = (mv != m_mod) ? 0 : m_acc;
        s    = base + nr;
        c    = (s >= mv) ? 1 : 0;
        m_acc = c ? s - mv : s;
        m_mod = mv;
        q.push_back('{int'(ratio_n) + c, m_acc * int'(dac_code)});
    endtask

    task automatic set_cfg(input int n, input int num, input bit m5, input int dac);
        ratio_n = 16'(n); frac_num = 3'(num); mod_sel = m5; dac_code = 8'(dac);
    endtask

    // Waits until just after the next cycle boundary.
    task automatic wait_boundary();
        do @(negedge clk); while (!div_pulse);
        @(posedge clk); #1;
    endtask

    task automatic run(input int k);
        repeat (k) begin
            push_next();
            wait_boundary();
        end
    endtask

    // Starts the loop with a sync strobe (R9).
    task automatic launch();
        @(posedge clk); #1;
        enable = 1'b1; ref_sync = 1'b1;
        m_acc = 0; m_mod = mod_sel ? 5 : 8;
        q.push_back('{int'(ratio_n), 0});
        @(posedge clk); #1;
        ref_sync = 1'b0;
    endtask

    // Counts clocks on which the outputs are not quiet.
    task automatic quiet(input int clocks, input string req);
        int bad = 0;
        repeat (clocks) begin
            @(negedge clk);
            if (div_pulse || comp_active || comp_code != 0) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Monitor: measures each cycle and compares it with the scoreboard.
    int len = 0, wid = 0, code_seen = 0;
    bit in_cycle = 0;
    always @(negedge clk) begin
        if (!rst_n || !enable) begin
            in_cycle = 0; len = 0; wid = 0;
        end else begin
            if (!in_cycle && comp_active) begin
                in_cycle = 1; len = 0; wid = 0; code_seen = 0;
            end
            if (in_cycle) begin
                len++;
                if (comp_active) begin wid++; code_seen = int'(comp_code); end
                if (div_pulse) begin
                    if (q.size() == 0) chk(0, "R1 unexpected pulse", len, 0);
                    else begin
                        item_t it;
                        it = q.pop_front();
                        chk(len == it.len, "R1 R2 R10 cycle length", len, it.len);
                        chk(wid == 128, "R6 window width", wid, 128);
                        chk(code_seen == it.code, "R7 code", code_seen, it.code);
                    end
                    len = 0; wid = 0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!div_pulse && !comp_active && comp_code == 0, "R11 reset outputs",
            int'(div_pulse) + int'(comp_active), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 R2 R7: modulo 5, numerator 2, nominal DAC code
        phase = "R2 mod5 num2";
        set_cfg(520, 2, 1'b1, 128);
        launch();
        run(10);

        // R4: mid-cycle changes restored before the boundary
        phase = "R4 mid-cycle glitch";
        set_cfg(600, 5, 1'b0, 33);
        repeat (200) @(posedge clk);
        #1 set_cfg(520, 2, 1'b1, 128);
        run(3);

        // R5: modulus change restarts the accumulator
        phase = "R5 switch to mod8";
        set_cfg(530, 3, 1'b0, 80);
        run(10);

        // R3: numerator reduced by the modulus
        phase = "R3 num7 at mod5";
        set_cfg(517, 7, 1'b1, 200);
        run(6);

        // R1: zero numerator never overflows
        phase = "R1 num0";
        set_cfg(524, 0, 1'b1, 255);
        run(3);

        // R10: minimum and maximum ratios
        phase = "R10 min ratio";
        set_cfg(512, 7, 1'b0, 255);
        run(5);
        phase = "R10 max ratio";
        set_cfg(65535, 7, 1'b0, 255);
        run(1);
        set_cfg(515, 1, 1'b0, 10);
        run(2);

        // R8: power-down clears and silences
        phase = "R8 power-down";
        enable = 1'b0;
        q.delete();
        @(posedge clk); #1;
        quiet(600, "R8 quiet while down");

        // R9: no start without sync, then a fresh first cycle
        phase = "R9 restart";
        enable = 1'b1;
        set_cfg(530, 5, 1'b0, 80);
        quiet(700, "R9 waits for sync");
        launch();
        run(5);

        chk(q.size() == 1, "R1 pending records", q.size(), 1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule